// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller erases a byte range of a NOR flash array that is 32 bits wide and made of two 16-bit devices side by side. Every command word it sends carries the same 16-bit code in both halves, so both devices receive it together. Software or a higher-level engine supplies a start address and a length in bytes and pulses `start`. The controller widens the range to whole 256 KiB erase blocks. It then works through the blocks one after another, from the lowest block to the highest.

For each block the controller sends an erase setup command and then a confirm command to the block's base address. It reads status at that address until both devices show ready. It keeps the status word, clears the status register and puts the array back into read mode. An erase failure reported by either device stops the run. A poll that never sees ready also stops the run, once a configurable number of polls has passed. In both cases the controller reports an error together with a byte offset. If every block erases cleanly it reports done. The flash bus uses a simple request/acknowledge handshake, and only one transfer is outstanding at any time.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `err_timeout` and `bus_req` are low and `err_offset` is 0.
- R2: The blocks erased run from `start_addr` rounded down to a multiple of 0x40000 up to `start_addr+length` rounded up to a multiple of 0x40000. They are visited in ascending order with a step of 0x40000, and every bus address is a block base.
- R3: Before the first block, one write of 0x00500050 (clear status) goes to the first block base.
- R4: For each block the controller writes 0x00200020 and then 0x00D000D0 to the block base, then reads the block base until bit 7 and bit 23 of the read data are both 1. One ready bit alone does not end polling. Every write has equal upper and lower 16-bit halves.
- R5: After polling ends, the controller writes 0x00500050 and then 0x00FF00FF to the block base.
- R6: If the captured status has bit 5 or bit 21 set, no further block is started. The controller raises `err` for one cycle with `err_timeout` low and `err_offset` = block base − `start_addr` + 1.
- R7: When all blocks erase without error, `done` pulses for one cycle with `err` low. `done` and `err` are never high together.
- R8: After POLL_LIMIT consecutive not-ready reads, the controller writes clear status and read mode, then raises `err` with `err_timeout` high. The offset follows the R6 formula.
- R9: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values. A transfer completes on a cycle where both are high.
- R10: `busy` goes high the cycle after an accepted start and stays high until the cycle in which `done` or `err` is high, when it is low. A `start` pulse while `busy` is ignored.
- R11: If the rounded range is empty (aligned start, zero length), only the clear-status write is issued, followed by `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, used only when idle |
| start_addr | input | 32 | First byte address of the range |
| length | input | 32 | Range length in bytes |
| busy | output | 1 | Erase run in progress |
| done | output | 1 | One-cycle pulse: all blocks erased |
| err | output | 1 | One-cycle pulse: run ended with an error |
| err_timeout | output | 1 | The last error was a poll timeout |
| err_offset | output | 32 | Failing block base − start address + 1 |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` on reads |

## Verification
The hardest cases to reach from the ports are a failure in one device only, in the middle of a multi-block range, and the split case where one device is ready and the other is not. The behavioural responder in the bench returns status in which only the low half is ready until a set number of polls have passed. It adds an error bit in just one half, and only at one chosen block address. The timeout case uses a responder mode that never reports ready, together with a small POLL_LIMIT.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int BLK_SHIFT  = 18,
  parameter int POLL_LIMIT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic [31:0] length,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        err_timeout,
  output logic [31:0] err_offset,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);
  localparam logic [31:0] BLK_SIZE = 32'd1 << BLK_SHIFT;
  localparam logic [31:0] BLK_MASK = BLK_SIZE - 32'd1;
  localparam int          PW       = $clog2(POLL_LIMIT + 1);
  localparam logic [31:0] CMD_CLR  = 32'h0050_0050;
  localparam logic [31:0] CMD_ERS  = 32'h0020_0020;
  localparam logic [31:0] CMD_CNF  = 32'h00D0_00D0;
  localparam logic [31:0] CMD_RD   = 32'h00FF_00FF;
  localparam logic [31:0] RDY_MASK = 32'h0080_0080;
  localparam logic [31:0] ERR_MASK = 32'h0020_0020;

  typedef enum logic [2:0] {S_IDLE, S_CLR0, S_SETUP, S_CONF, S_POLL, S_CLR1, S_READ} st_t;

  st_t         state;
  logic [31:0] cur, org, left, stat_q;
  logic [PW-1:0] poll_cnt;
  logic        tmo_q;

  wire [31:0] base_in = start_addr & ~BLK_MASK;
  wire [31:0] end_up  = (start_addr + length + BLK_MASK) & ~BLK_MASK;
  wire [31:0] nblk_in = (end_up - base_in) >> BLK_SHIFT;
  wire        xfer    = bus_req & bus_ack;
  wire        ready   = (bus_rdata & RDY_MASK) == RDY_MASK;
  wire        failed  = tmo_q | ((stat_q & ERR_MASK) != 32'd0);

  assign busy     = state != S_IDLE;
  assign bus_req  = busy;
  assign bus_we   = state != S_POLL;
  assign bus_addr = cur;

  always_comb begin
    case (state)
      S_CLR0, S_CLR1: bus_wdata = CMD_CLR;
      S_SETUP:        bus_wdata = CMD_ERS;
      S_CONF:         bus_wdata = CMD_CNF;
      S_READ:         bus_wdata = CMD_RD;
      default:        bus_wdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cur         <= '0;
      org         <= '0;
      left        <= '0;
      stat_q      <= '0;
      poll_cnt    <= '0;
      tmo_q       <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      err_timeout <= 1'b0;
      err_offset  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          org         <= start_addr;
          cur         <= base_in;
          left        <= nblk_in;
          err_timeout <= 1'b0;
          err_offset  <= '0;
          state       <= S_CLR0;
        end
        S_CLR0: if (xfer) begin
          if (left == 32'd0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_SETUP;
          end
        end
        S_SETUP: if (xfer) begin
          poll_cnt <= '0;
          state    <= S_CONF;
        end
        S_CONF: if (xfer) state <= S_POLL;
        S_POLL: if (xfer) begin
          if (ready) begin
            stat_q <= bus_rdata;
            tmo_q  <= 1'b0;
            state  <= S_CLR1;
          end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
            stat_q <= '0;
            tmo_q  <= 1'b1;
            state  <= S_CLR1;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        S_CLR1: if (xfer) state <= S_READ;
        S_READ: if (xfer) begin
          if (failed) begin
            err         <= 1'b1;
            err_timeout <= tmo_q;
            err_offset  <= cur - org + 32'd1;
            state       <= S_IDLE;
          end else if (left == 32'd1) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cur   <= cur + BLK_SIZE;
            left  <= left - 32'd1;
            state <= S_SETUP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));
  a_r7_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  a_r10_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);
  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r2_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr & BLK_MASK) == 32'd0);
  a_r4_dup_halves: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_wdata[31:16] == bus_wdata[15:0]);
  a_r8_timeout_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> err);
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] start_addr = 0, length = 0;
  logic busy, done, err, err_timeout, bus_req, bus_we, bus_ack;
  logic [31:0] err_offset, bus_addr, bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(.BLK_SHIFT(18), .POLL_LIMIT(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
    .busy(busy), .done(done), .err(err), .err_timeout(err_timeout), .err_offset(err_offset),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int checks = 0, fails = 0, cycles = 0;
  int ready_after = 2;
  logic never_ready = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF, err_word = 0;
  int rd_cnt = 0;

  logic        lg_we [512];
  logic [31:0] lg_addr [512], lg_data [512];
  int lg_n = 0;
  logic        ex_we [512];
  logic [31:0] ex_addr [512], ex_data [512];
  int ex_n = 0;
  logic hold_bad = 0;
  logic [31:0] prev_addr, prev_data;

  assign bus_rdata = (never_ready || rd_cnt < ready_after) ? 32'h0000_0080
                   : (32'h0080_0080 | ((bus_addr == err_addr) ? err_word : 32'd0));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      bus_ack <= 0;
      rd_cnt  <= 0;
    end else begin
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && !bus_ack) begin prev_addr <= bus_addr; prev_data <= bus_wdata; end
      if (bus_req && bus_ack) begin
        if (bus_addr != prev_addr || bus_wdata != prev_data) hold_bad <= 1;
        if (lg_n < 512) begin
          lg_we[lg_n]   <= bus_we;
          lg_addr[lg_n] <= bus_addr;
          lg_data[lg_n] <= bus_we ? bus_wdata : 32'd0;
          lg_n <= lg_n + 1;
        end
        if (bus_we && bus_wdata == 32'h00D0_00D0) rd_cnt <= 0;
        else if (!bus_we) rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(posedge clk) if (cycles > 150000) begin
    fails = fails + 1;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d);
    ex_we[ex_n] = we; ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_n++;
  endtask

  task automatic build(input logic [31:0] sa, input logic [31:0] len);
    logic [31:0] base, top, a;
    base = sa & ~32'h3FFFF;
    top  = (sa + len + 32'h3FFFF) & ~32'h3FFFF;
    ex_n = 0;
    push(1, base, 32'h0050_0050);
    for (a = base; a != top; a += 32'h40000) begin
      push(1, a, 32'h0020_0020);
      push(1, a, 32'h00D0_00D0);
      for (int k = 0; k < (never_ready ? PL : ready_after + 1); k++) push(0, a, 0);
      push(1, a, 32'h0050_0050);
      push(1, a, 32'h00FF_00FF);
      if (never_ready || (a == err_addr && err_word != 0)) break;
    end
  endtask

  task automatic run(input logic [31:0] sa, input logic [31:0] len, input string tag,
                     input bit poke);
    bit busy_ok = 1;
    int n = 0;
    build(sa, len);
    lg_n = 0; hold_bad = 0;
    @(negedge clk);
    start_addr = sa; length = len; start = 1;
    @(negedge clk);
    start = 0;
    while (!(done || err) && n < 5000) begin
      if (!busy) busy_ok = 0;
      n++;
      if (poke && n == 6) begin start = 1; start_addr = 32'h00F0_0000; length = 32'h10; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    check(busy_ok, {tag, " R10 busy held during run"}, busy_ok, 1);
    check(!busy, {tag, " R10 busy low at end"}, busy, 0);
    check(!hold_bad, {tag, " R9 request held until ack"}, hold_bad, 0);
    check(lg_n == ex_n, {tag, " R2 transfer count"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      if (lg_we[i] != ex_we[i] || lg_addr[i] != ex_addr[i] || lg_data[i] != ex_data[i]) begin
        check(0, $sformatf("%s R3/R4/R5 transfer %0d addr", tag, i), lg_addr[i], ex_addr[i]);
        check(0, $sformatf("%s R3/R4/R5 transfer %0d data", tag, i), lg_data[i], ex_data[i]);
        break;
      end
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(!busy && !bus_req, "R1 idle after reset", {busy, bus_req}, 0);
    check(!done && !err && !err_timeout, "R1 flags low", {done, err, err_timeout}, 0);
    check(err_offset == 0, "R1 offset zero", err_offset, 0);
  endtask

  task automatic t_ok(input logic [31:0] sa, input logic [31:0] len, input int ra, input string tag);
    logic d, e;
    ready_after = ra; never_ready = 0; err_word = 0; err_addr = 32'hFFFF_FFFF;
    fork
      run(sa, len, tag, 0);
      begin @(posedge (done || err)); #1 d = done; e = err; end
    join
    check(d && !e, {tag, " R7 done without err"}, {d, e}, 2'b10);
  endtask

  task automatic t_err(input logic [31:0] sa, input logic [31:0] len, input logic [31:0] ea,
                       input logic [31:0] ew, input bit nr, input string tag);
    logic e, t; logic [31:0] off;
    ready_after = 3; never_ready = nr; err_addr = ea; err_word = ew;
    fork
      run(sa, len, tag, 0);
      begin @(posedge (done || err)); #1 e = err; end
    join
    t = err_timeout; off = err_offset;
    check(e, {tag, nr ? " R8 err raised" : " R6 err raised"}, e, 1);
    check(t == nr, {tag, nr ? " R8 timeout flag" : " R6 timeout flag low"}, t, nr);
    check(off == ea - sa + 1, {tag, " R6 offset"}, off, ea - sa + 1);
    never_ready = 0; err_word = 0; err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_poke;
    logic d;
    ready_after = 4; never_ready = 0; err_word = 0; err_addr = 32'hFFFF_FFFF;
    fork
      run(32'h0014_0000, 32'h4_0000, "poke", 1);
      begin @(posedge (done || err)); #1 d = done; end
    join
    check(d, "R10 start while busy ignored, run completes", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_ok(32'h0004_1234, 32'h100, 3, "single_unaligned");
    t_ok(32'h0007_FFF0, 32'h20, 1, "cross_boundary");
    t_ok(32'h0010_0000, 32'hC_0000, 0, "aligned_three");
    t_ok(32'h0030_0000, 32'h0, 2, "R11 empty_range");
    t_err(32'h0004_0010, 32'h8_0000, 32'h0008_0000, 32'h0000_0020, 0, "err_low_mid");
    t_err(32'h0020_0008, 32'h4_0000, 32'h0020_0000, 32'h0020_0000, 0, "err_high_first");
    t_err(32'h0020_0000, 32'h4, 32'h0020_0000, 32'h0, 1, "R8 timeout");
    t_poke();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule